// File: doc/BRIEF.md
# Interrupt Pending Selector

This block decides which local interrupt a hart should take next. Each cycle it samples a pending vector, an enable vector, a delegation mask, the current privilege level and the two global interrupt-enable bits for the machine and supervisor levels. It first forms the set of raw candidates. It then qualifies each candidate with the enable that applies to the level it is routed to. Finally it reports the lowest-numbered surviving cause.

A cause whose delegation bit is clear is handled at machine level. A cause whose delegation bit is set is handled at supervisor level. Code running below a level can always be interrupted by that level. Code running at that level can be interrupted only when that level's global enable is set. Code running above that level is never interrupted by it. Both the inputs and the result are registered, so the block drops into a pipeline without adding to any combinational path.

Top module: `irqsel_top`

## Requirements
- R1: The raw candidate set is the bitwise AND of the pending and enable vectors. A pending bit whose enable bit is clear is never selected.
- R2: A non-delegated candidate is eligible when the privilege code is below 3 (machine), or when the code is 3 and the machine global enable is 1.
- R3: A delegated candidate is eligible when the privilege code is 0 (user), or when the code is 1 (supervisor) and the supervisor global enable is 1.
- R4: Each candidate bit goes through exactly one gate, chosen by its own delegation bit: bit clear uses the machine gate, bit set uses the supervisor gate. The result is the OR of the two gated sets.
- R5: When the eligible set is non-empty, `irq_valid` is 1 and `irq_index` is the position of its least-significant set bit. Bit 0 has the highest priority.
- R6: When the eligible set is empty, `irq_valid` is 0 and `irq_index` is 0.
- R7: Inputs are captured at one rising clock edge. The result for them appears on the outputs after the next rising edge and holds until the edge after that.
- R8: Reset is synchronous and active low. A rising edge with `rst_n` at 0 clears both register stages, so the outputs read valid 0 and index 0 after that edge and after the first edge following release.
- R9: The unused privilege code 2 is compared numerically: it counts as below machine and above supervisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pend | input | XLEN | Pending interrupt bits, one per cause |
| enab | input | XLEN | Per-cause enable bits |
| deleg | input | XLEN | Delegation mask; a set bit routes that cause to supervisor level |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine-level global interrupt enable |
| s_gie | input | 1 | Supervisor-level global interrupt enable |
| irq_valid | output | 1 | An eligible interrupt exists |
| irq_index | output | $clog2(XLEN) | Cause number of the selected interrupt |

## Verification
The bench builds two copies of the block. The first uses the default width of 64. It covers the top cause number, 63, and the hand-computed table of routing cases, and it runs random full-width vectors against a reference model. The second uses a width of 8. This makes it cheap to sweep every pending pattern against every privilege code and every global-enable pair, under two complementary delegation masks. That sweep reaches every combination of gate outcomes, including the unused privilege code.

// File: rtl/irqsel_pkg.sv
// Package: shared privilege encoding for the interrupt selector.
// Assumes the two-bit privilege code is compared numerically; code 2 is unused.
package irqsel_pkg;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

endpackage

// File: rtl/irqsel_gate.sv
// Module: irqsel_gate
// Forms the eligible interrupt set from candidates, delegation and the
// per-level enables. Purely combinational. Assumes priv is numerically ordered.
module irqsel_gate
    import irqsel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pend,
    input  logic [XLEN-1:0] enab,
    input  logic [XLEN-1:0] deleg,
    input  priv_e           priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic [XLEN-1:0] elig
);

    logic            m_open;
    logic            s_open;
    logic [XLEN-1:0] cand;

    // Level gates: lower privilege is always open, equal privilege needs the global bit.
    always_comb begin
        m_open = (priv < PRV_MACH)  || ((priv == PRV_MACH)  && m_gie);
        s_open = (priv < PRV_SUPER) || ((priv == PRV_SUPER) && s_gie);
    end

    // Route each candidate through the gate its delegation bit selects.
    always_comb begin
        cand = pend & enab;
        elig = (cand & ~deleg & {XLEN{m_open}}) |
               (cand &  deleg & {XLEN{s_open}});
    end

endmodule

// File: rtl/irqsel_lsb.sv
// Module: irqsel_lsb
// Priority encoder: reports the position of the least-significant set bit.
// Index is zero when no bit is set. Combinational.
module irqsel_lsb #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest set bit is written last and wins.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irqsel_top.sv
// Module: irqsel_top
// Selects the local interrupt a hart should take. Inputs are registered,
// gated by delegation and privilege, priority-encoded (lowest cause first)
// and the result registered. Latency: captured at edge N, visible after N+1.
// Assumes a synchronous active-low reset and XLEN >= 2.
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int IDXW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend,
    input  logic [XLEN-1:0] enab,
    input  logic [XLEN-1:0] deleg,
    input  logic [1:0]      priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic            irq_valid,
    output logic [IDXW-1:0] irq_index
);

    logic [XLEN-1:0] pend_q;
    logic [XLEN-1:0] enab_q;
    logic [XLEN-1:0] deleg_q;
    priv_e           priv_q;
    logic            m_gie_q;
    logic            s_gie_q;
    logic [XLEN-1:0] elig;
    logic            hit;
    logic [IDXW-1:0] hit_idx;

    // Input stage: capture the sampled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            enab_q  <= '0;
            deleg_q <= '0;
            priv_q  <= PRV_USER;
            m_gie_q <= 1'b0;
            s_gie_q <= 1'b0;
        end else begin
            pend_q  <= pend;
            enab_q  <= enab;
            deleg_q <= deleg;
            priv_q  <= priv_e'(priv);
            m_gie_q <= m_gie;
            s_gie_q <= s_gie;
        end
    end

    irqsel_gate #(.XLEN(XLEN)) u_gate (
        .pend  (pend_q),
        .enab  (enab_q),
        .deleg (deleg_q),
        .priv  (priv_q),
        .m_gie (m_gie_q),
        .s_gie (s_gie_q),
        .elig  (elig)
    );

    irqsel_lsb #(.W(XLEN), .IW(IDXW)) u_lsb (
        .vec   (elig),
        .found (hit),
        .idx   (hit_idx)
    );

    // Output stage: register the selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_index <= '0;
        end else begin
            irq_valid <= hit;
            irq_index <= hit_idx;
        end
    end

endmodule

// File: rtl/irqsel_chk.sv
// Module: irqsel_chk
// Property checker for irqsel_top, attached by bind. It keeps its own
// two-deep history of the inputs so results can be tied to the cycle they
// came from. Assumes the top's two-edge input-to-output pipeline.
module irqsel_chk #(
    parameter int XLEN = 64,
    localparam int IDXW = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pend,
    input logic [XLEN-1:0] enab,
    input logic [XLEN-1:0] deleg,
    input logic [1:0]      priv,
    input logic            m_gie,
    input logic            s_gie,
    input logic            irq_valid,
    input logic [IDXW-1:0] irq_index
);

    logic [XLEN-1:0] cand_d1, cand_d2;
    logic [1:0]      priv_d1, priv_d2;
    logic            mg_d1, mg_d2;
    logic            started = 1'b0;

    // History of the candidate set, privilege and machine enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_d1 <= '0;
            cand_d2 <= '0;
            priv_d1 <= '0;
            priv_d2 <= '0;
            mg_d1   <= 1'b0;
            mg_d2   <= 1'b0;
        end else begin
            cand_d1 <= pend & enab;
            cand_d2 <= cand_d1;
            priv_d1 <= priv;
            priv_d2 <= priv_d1;
            mg_d1   <= m_gie;
            mg_d2   <= mg_d1;
        end
    end

    // Marks that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) started <= 1'b1;

    // R1
    pick_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> cand_d2[irq_index]);

    // R6
    empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_d2 == '0) |-> !irq_valid);

    // R6
    idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_index == '0));

    // R2
    user_always_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_d2 == 2'd0) && (cand_d2 != '0)) |-> irq_valid);

    // R2
    mach_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_d2 == 2'd3) && !mg_d2) |-> !irq_valid);

    // R5
    user_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (priv_d2 == 2'd0)) |->
            ((cand_d2 & ((XLEN'(1) << irq_index) - XLEN'(1))) == '0));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        (started && !$past(rst_n)) |-> (!irq_valid && (irq_index == '0)));

endmodule

bind irqsel_top irqsel_chk #(.XLEN(XLEN)) u_irqsel_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .enab      (enab),
    .deleg     (deleg),
    .priv      (priv),
    .m_gie     (m_gie),
    .s_gie     (s_gie),
    .irq_valid (irq_valid),
    .irq_index (irq_index)
);

// File: tb/test_irqsel_top.sv
// Bench for irqsel_top: a table of hand-computed cases on a 64-bit copy,
// random vectors against a reference model, an exhaustive sweep on an
// 8-bit copy, and directed latency and reset checks.
module test_irqsel_top;

    localparam logic [63:0] ALL = '1;

    typedef struct packed {
        logic [63:0] p;
        logic [63:0] e;
        logic [63:0] d;
        logic [1:0]  pr;
        logic        mg;
        logic        sg;
        logic        ev;
        logic [5:0]  ei;
        logic [3:0]  rq;
    } row_t;

    localparam int NROW = 14;
    localparam row_t TBL [NROW] = '{
        '{64'h0,   ALL,                    64'h0,  2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  4'd6}, // R6 nothing pending
        '{64'h220, ALL,                    64'h0,  2'd0, 1'b0, 1'b0, 1'b1, 6'd5,  4'd5}, // R5 lowest of 5,9
        '{64'h220, 64'hFFFF_FFFF_FFFF_FFDF, 64'h0, 2'd0, 1'b0, 1'b0, 1'b1, 6'd9,  4'd1}, // R1 bit5 disabled
        '{64'h8,   ALL,                    64'h0,  2'd3, 1'b0, 1'b0, 1'b0, 6'd0,  4'd2}, // R2 M, gie off
        '{64'h8,   ALL,                    64'h0,  2'd3, 1'b1, 1'b0, 1'b1, 6'd3,  4'd2}, // R2 M, gie on
        '{64'h88,  ALL,                    64'h8,  2'd1, 1'b0, 1'b0, 1'b1, 6'd7,  4'd3}, // R3 S, sie off
        '{64'h88,  ALL,                    64'h8,  2'd1, 1'b0, 1'b1, 1'b1, 6'd3,  4'd3}, // R3 S, sie on
        '{64'h4,   ALL,                    ALL,    2'd3, 1'b1, 1'b1, 1'b0, 6'd0,  4'd4}, // R4 delegated at M
        '{64'h8000_0000_0000_0000, ALL,    ALL,    2'd0, 1'b0, 1'b0, 1'b1, 6'd63, 4'd5}, // R5 top cause
        '{64'h10,  ALL,                    64'h0,  2'd2, 1'b0, 1'b1, 1'b1, 6'd4,  4'd9}, // R9 code 2 below M
        '{64'h10,  ALL,                    64'h10, 2'd2, 1'b1, 1'b1, 1'b0, 6'd0,  4'd9}, // R9 code 2 above S
        '{ALL,     ALL,                    64'h0,  2'd0, 1'b0, 1'b0, 1'b1, 6'd0,  4'd5}, // R5 all pending
        '{64'h42,  ALL,                    64'h2,  2'd3, 1'b1, 1'b0, 1'b1, 6'd6,  4'd4}, // R4 bit1 blocked at M
        '{64'h42,  ALL,                    64'h40, 2'd1, 1'b1, 1'b0, 1'b1, 6'd1,  4'd4}  // R4 bit1 to machine
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [63:0] p64 = '0, e64 = '0, d64 = '0;
    logic [1:0]  pr64 = '0;
    logic        mg64 = 1'b0, sg64 = 1'b0;
    logic        v64;
    logic [5:0]  ix64;

    logic [7:0]  p8 = '0, e8 = '0, d8 = '0;
    logic [1:0]  pr8 = '0;
    logic        mg8 = 1'b0, sg8 = 1'b0;
    logic        v8;
    logic [2:0]  ix8;

    int n_cmp = 0;
    int n_bad = 0;

    irqsel_top #(.XLEN(64)) i_irqsel_top (
        .clk(clk), .rst_n(rst_n), .pend(p64), .enab(e64), .deleg(d64),
        .priv(pr64), .m_gie(mg64), .s_gie(sg64),
        .irq_valid(v64), .irq_index(ix64)
    );

    irqsel_top #(.XLEN(8)) i_irqsel_top_w8 (
        .clk(clk), .rst_n(rst_n), .pend(p8), .enab(e8), .deleg(d8),
        .priv(pr8), .m_gie(mg8), .s_gie(sg8),
        .irq_valid(v8), .irq_index(ix8)
    );

    // Reference model written from the requirements.
    task automatic ref_pick(input logic [63:0] p, input logic [63:0] e,
                            input logic [63:0] d, input logic [1:0] pr,
                            input logic mg, input logic sg,
                            output logic v, output int ix);
        logic mok, sok;
        mok = (pr < 2'd3) || (pr == 2'd3 && mg);
        sok = (pr < 2'd1) || (pr == 2'd1 && sg);
        v = 1'b0;
        ix = 0;
        for (int i = 0; i < 64; i++) begin
            if (!v && p[i] && e[i] && (d[i] ? sok : mok)) begin
                v = 1'b1;
                ix = i;
            end
        end
    endtask

    task automatic chk(input string tag, input logic av, input int ai,
                       input logic ev, input int ei);
        n_cmp++;
        if (av !== ev || ai != ei) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b index=%0d, expected valid=%0b index=%0d",
                     tag, av, ai, ev, ei);
        end
    endtask

    // Apply at a falling edge, wait for the two register stages, sample mid-cycle.
    task automatic settle();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic ev;
        int   ei;

        // R8 reset state
        repeat (3) @(negedge clk);
        chk("R8 reset state 64", v64, int'(ix64), 1'b0, 0);
        chk("R8 reset state 8", v8, int'(ix8), 1'b0, 0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R9
        for (int r = 0; r < NROW; r++) begin
            p64 = TBL[r].p; e64 = TBL[r].e; d64 = TBL[r].d;
            pr64 = TBL[r].pr; mg64 = TBL[r].mg; sg64 = TBL[r].sg;
            settle();
            chk($sformatf("R%0d table row %0d", TBL[r].rq, r),
                v64, int'(ix64), TBL[r].ev, int'(TBL[r].ei));
        end

        // R5 R4 random full-width vectors against the model
        for (int k = 0; k < 400; k++) begin
            p64 = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            e64 = {$urandom(), $urandom()} | {$urandom(), $urandom()};
            d64 = {$urandom(), $urandom()};
            pr64 = 2'($urandom());
            mg64 = 1'($urandom());
            sg64 = 1'($urandom());
            settle();
            ref_pick(p64, e64, d64, pr64, mg64, sg64, ev, ei);
            chk("R5 random 64-bit", v64, int'(ix64), ev, ei);
        end

        // R2 R3 R9 exhaustive sweep on the 8-bit copy
        e8 = 8'hFF;
        for (int dm = 0; dm < 2; dm++) begin
            for (int pv = 0; pv < 4; pv++) begin
                for (int g = 0; g < 4; g++) begin
                    for (int pp = 0; pp < 256; pp++) begin
                        d8 = (dm == 0) ? 8'hA5 : 8'h5A;
                        pr8 = 2'(pv);
                        mg8 = g[0];
                        sg8 = g[1];
                        p8 = 8'(pp);
                        settle();
                        ref_pick({56'h0, p8}, {56'h0, e8}, {56'h0, d8},
                                 pr8, mg8, sg8, ev, ei);
                        chk("R3 sweep 8-bit", v8, int'(ix8), ev, ei);
                    end
                end
            end
        end

        // R7 latency: one edge after a change the old result still shows
        p64 = 64'h20; e64 = ALL; d64 = '0; pr64 = 2'd0; mg64 = 1'b0; sg64 = 1'b0;
        settle();
        chk("R7 baseline", v64, int'(ix64), 1'b1, 5);
        p64 = 64'h800;
        @(posedge clk);
        @(negedge clk);
        chk("R7 one edge later holds old", v64, int'(ix64), 1'b1, 5);
        @(posedge clk);
        @(negedge clk);
        chk("R7 two edges later shows new", v64, int'(ix64), 1'b1, 11);

        // R8 reset mid-run clears the outputs
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 reset while active", v64, int'(ix64), 1'b0, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 first edge after release", v64, int'(ix64), 1'b0, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 second edge after release", v64, int'(ix64), 1'b1, 11);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule